// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Set/Clear Status Registers

This block is a single-channel asynchronous serial port behind a byte-wide register file. A host writes bytes into a one-byte transmit holding register, and the block frames and shifts them out. Frames carry 7 or 8 data bits, least significant bit first, an optional even or odd parity bit, and one or two stop bits. The receiver oversamples its input 16 times per bit. It rebuilds each byte, keeps it in a one-byte receive buffer, and records framing, parity, overrun and break conditions in sticky flags.

Each of the two status registers has two write ports at different offsets. A write of ones to one port clears the matching bits, and a write of ones to the other port sets them, so software can both acknowledge and inject events. Control bits select a loopback test mode and an auto-echo mode, and the transmitter can force a break on the line. A single interrupt output combines receive-side and transmit-side sources. The bit rate comes from a 16-bit divisor split over two byte registers: divisor = clock / (16 × baud) − 1.

Top module: `serport_top`

## Requirements
- R1: After reset, offset 0x00 reads 0x06, `txd` is high, and `irq`, `dtrOut` and `rtsOut` are low.
- R2: When transmit command bit7 is set, a byte written to offset 0x24 is sent as one low start bit, then the data LSB first (8 bits if control bit3 = 1, else 7), then a parity bit if control bit2 = 1 (odd when bit1 = 1, even when bit1 = 0), then one stop bit, or two when control bit0 = 1. Nothing is sent while bit7 is clear.
- R3: Every bit lasts 16 × (D + 1) clocks, where D is the divisor: high byte at 0x10, low byte at 0x14.
- R4: With receive command bit7 set, a received frame sets line status bit7 (data ready), and the byte reads back at 0x24. Reading 0x24 clears bit7.
- R5: A good frame that completes while data ready is set sets line status bit5 (overrun) and leaves the buffered byte unchanged.
- R6: A low first stop bit sets line status bit6 (framing). A parity mismatch sets bit4. The byte is still delivered.
- R7: A frame whose samples are all low, stop bit included, sets line status bit3 (break) and does not set data ready.
- R8: Writing ones to 0x00 clears the matching line status bits 7..3, and writing ones to 0x04 sets them. Those bits otherwise stay set.
- R9: Line status bit2 is 1 while the holding byte is empty, and bit1 is 1 while the shifter is idle.
- R10: With control bit6 set, the transmitted frame reaches the receiver internally and `txd` stays high.
- R11: With control bit7 set, each received byte is transmitted again, and host writes to 0x24 are ignored (bit2 stays 1).
- R12: While transmit command bit1 is set (and not in loopback), `txd` is held low.
- R13: `irq` is high when (receive command bits 6:5 = 01 and data ready), or (receive command bit4 and any of line status bits 6..3), or (transmit command bits 6:5 = 01, transmit command bit4 and line status bit2). Otherwise it is low.
- R14: Offset 0x08 reads DSR level in bit7, CTS level in bit6, a latched DSR change in bit1 and a latched CTS change in bit0. Writing ones to 0x08 clears bits 1:0, and writing ones to 0x0C sets them. `dtrOut` follows control bit5 and `rtsOut` follows control bit4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (read side effects) |
| busAddr | input | 6 | Byte offset of the register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| dsrIn | input | 1 | Data-set-ready level |
| ctsIn | input | 1 | Clear-to-send level |
| dtrOut | output | 1 | Data-terminal-ready from control |
| rtsOut | output | 1 | Request-to-send from control |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit divisor width. At run time it programs divisors of 0 and 2, which give bit periods of 16 and 48 clocks, so the timing rule can be checked on two rates. All frame formats are reachable at divisor 0 within a few hundred clocks per byte. This makes the 7-bit, parity, two-stop, break, overrun, loopback and echo cases short enough to run in sequence in one run.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int OVS     = 16;
  localparam int OVS_W   = $clog2(OVS);
  localparam int FRAME_W = 12;

  localparam logic [5:0] OFS_LSR_CLR = 6'h00;
  localparam logic [5:0] OFS_LSR_SET = 6'h04;
  localparam logic [5:0] OFS_HS_CLR  = 6'h08;
  localparam logic [5:0] OFS_HS_SET  = 6'h0C;
  localparam logic [5:0] OFS_DIV_HI  = 6'h10;
  localparam logic [5:0] OFS_DIV_LO  = 6'h14;
  localparam logic [5:0] OFS_CTRL    = 6'h18;
  localparam logic [5:0] OFS_RXCMD   = 6'h1C;
  localparam logic [5:0] OFS_TXCMD   = 6'h20;
  localparam logic [5:0] OFS_DATA    = 6'h24;

  typedef struct packed {
    logic       txLoad;
    logic [7:0] txByte;
  } ctlStrobe_t;

  typedef struct packed {
    logic       rxDone;
    logic [7:0] rxByte;
    logic       rxFe;
    logic       rxPe;
    logic       rxBrk;
    logic       holdEmpty;
    logic       shiftEmpty;
  } dpEvent_t;

  // Whole frame, start bit at position 0, unused upper positions high.
  function automatic logic [FRAME_W-1:0] buildFrame(input logic [7:0] d, input logic eight,
                                                    input logic parEn, input logic parOdd);
    logic [FRAME_W-1:0] f;
    logic [7:0] dm;
    dm = eight ? d : {1'b0, d[6:0]};
    f = '1;
    f[0] = 1'b0;
    f[8:1] = dm;
    if (!eight) f[8] = 1'b1;
    if (parEn) begin
      if (eight) f[9] = (^dm) ^ parOdd;
      else       f[8] = (^dm) ^ parOdd;
    end
    return f;
  endfunction

  function automatic logic [3:0] frameLen(input logic eight, input logic parEn, input logic twoStop);
    return 4'd9 + {3'b0, eight} + {3'b0, parEn} + {3'b0, twoStop};
  endfunction
endpackage

// File: rtl/serport_dp.sv
module serport_dp import serport_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             eight,
  input  logic             parEn,
  input  logic             parOdd,
  input  logic             twoStop,
  input  logic             loopMode,
  input  logic             rxEn,
  input  logic             txEn,
  input  logic             txBreak,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxdPin,
  output logic             txdPin,
  output dpEvent_t         evt
);
  localparam logic [OVS_W-1:0] OVS_LAST  = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] HALF_LAST = OVS_W'(OVS / 2 - 1);

  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= divisor);
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) divCnt <= '0;
    else       divCnt <= tick ? '0 : divCnt + 1'b1;

  // Transmit path
  logic [7:0]         holdReg;
  logic               holdFull, txBusy;
  logic [FRAME_W-1:0] txShift;
  logic [3:0]         txBitsLeft;
  logic [OVS_W-1:0]   txTick;
  logic               startTx, txSerial, rxLine;

  assign startTx = txEn && holdFull && !txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0; holdFull <= 1'b0; txBusy <= 1'b0;
      txShift <= '1; txBitsLeft <= '0; txTick <= '0;
    end else begin
      if (startTx) holdFull <= 1'b0;
      if (strobe.txLoad) begin
        holdReg  <= strobe.txByte;
        holdFull <= 1'b1;
      end
      if (startTx) begin
        txShift    <= buildFrame(holdReg, eight, parEn, parOdd);
        txBitsLeft <= frameLen(eight, parEn, twoStop);
        txTick     <= '0;
        txBusy     <= 1'b1;
      end else if (txBusy && tick) begin
        if (txTick == OVS_LAST) begin
          txShift    <= {1'b1, txShift[FRAME_W-1:1]};
          txTick     <= '0;
          txBitsLeft <= txBitsLeft - 1'b1;
          if (txBitsLeft == 4'd1) txBusy <= 1'b0;
        end else begin
          txTick <= txTick + 1'b1;
        end
      end
    end
  end

  assign txSerial = txBreak ? 1'b0 : (txBusy ? txShift[0] : 1'b1);
  assign txdPin   = loopMode ? 1'b1 : txSerial;
  assign rxLine   = loopMode ? txSerial : rxdPin;

  // Receive path
  typedef enum logic [1:0] {RX_HUNT, RX_IDLE, RX_START, RX_DATA} rxState_t;
  rxState_t         rxState;
  logic [OVS_W-1:0] rxTick;
  logic [3:0]       rxIdx, nSamp;
  logic [10:0]      rxSamp;
  logic             rxDoneQ;

  assign nSamp = 4'd8 + {3'b0, eight} + {3'b0, parEn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_HUNT; rxTick <= '0; rxIdx <= '0; rxSamp <= '0; rxDoneQ <= 1'b0;
    end else begin
      rxDoneQ <= 1'b0;
      if (!rxEn) rxState <= RX_HUNT;
      else if (tick) begin
        unique case (rxState)
          RX_HUNT: if (rxLine) rxState <= RX_IDLE;
          RX_IDLE: if (!rxLine) begin rxState <= RX_START; rxTick <= OVS_W'(1); end
          RX_START:
            if (rxLine) rxState <= RX_IDLE;
            else if (rxTick == HALF_LAST) begin
              rxState <= RX_DATA; rxTick <= '0; rxIdx <= '0; rxSamp <= '0;
            end else rxTick <= rxTick + 1'b1;
          RX_DATA:
            if (rxTick == OVS_LAST) begin
              rxSamp[rxIdx] <= rxLine;
              rxTick <= '0;
              if (rxIdx == nSamp - 4'd1) begin rxState <= RX_HUNT; rxDoneQ <= 1'b1; end
              else rxIdx <= rxIdx + 1'b1;
            end else rxTick <= rxTick + 1'b1;
          default: rxState <= RX_HUNT;
        endcase
      end
    end
  end

  logic [7:0] rxData;
  logic       parBit, stopBit;
  assign rxData  = eight ? rxSamp[7:0] : {1'b0, rxSamp[6:0]};
  assign parBit  = eight ? rxSamp[8] : rxSamp[7];
  assign stopBit = rxSamp[nSamp - 4'd1];

  always_comb begin
    evt.rxDone     = rxDoneQ;
    evt.rxByte     = rxData;
    evt.rxBrk      = (rxSamp == '0);
    evt.rxFe       = !stopBit && !evt.rxBrk;
    evt.rxPe       = parEn && (parBit != ((^rxData) ^ parOdd));
    evt.holdEmpty  = !holdFull;
    evt.shiftEmpty = !txBusy;
  end
endmodule

// File: rtl/serport_ctl.sv
module serport_ctl import serport_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [5:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             dsrIn,
  input  logic             ctsIn,
  input  dpEvent_t         evt,
  output ctlStrobe_t       strobe,
  output logic [7:0]       ctrlReg,
  output logic [7:0]       rxCmdReg,
  output logic [7:0]       txCmdReg,
  output logic [7:0]       lsrView,
  output logic [DIV_W-1:0] divisor,
  output logic             irq
);
  logic [7:0] divHi, divLo, rxBuf;
  logic [4:0] sticky;          // {ready, framing, overrun, parity, break}
  logic [1:0] hsChg;           // {dsr change, cts change}
  logic       dsrQ, ctsQ;
  logic       goodEv, newByte, dataRd;
  logic [4:0] hwSet, swClr, swSet;

  assign goodEv  = evt.rxDone && !evt.rxBrk;
  assign newByte = goodEv && !sticky[4];
  assign dataRd  = rdEn && addr == OFS_DATA;
  assign hwSet   = {newByte, goodEv && evt.rxFe, goodEv && sticky[4],
                    goodEv && evt.rxPe, evt.rxDone && evt.rxBrk};
  assign swClr   = (wrEn && addr == OFS_LSR_CLR) ? wrData[7:3] : 5'b0;
  assign swSet   = (wrEn && addr == OFS_LSR_SET) ? wrData[7:3] : 5'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divHi <= '0; divLo <= '0; ctrlReg <= '0; rxCmdReg <= '0; txCmdReg <= '0;
      rxBuf <= '0; sticky <= '0; hsChg <= '0; dsrQ <= 1'b0; ctsQ <= 1'b0;
    end else begin
      if (wrEn) begin
        unique case (addr)
          OFS_DIV_HI: divHi    <= wrData;
          OFS_DIV_LO: divLo    <= wrData;
          OFS_CTRL:   ctrlReg  <= wrData;
          OFS_RXCMD:  rxCmdReg <= wrData;
          OFS_TXCMD:  txCmdReg <= wrData;
          default: ;
        endcase
      end
      if (newByte) rxBuf <= evt.rxByte;
      sticky <= ((sticky & ~swClr & ~{dataRd, 4'b0}) | swSet | hwSet);
      dsrQ <= dsrIn;
      ctsQ <= ctsIn;
      hsChg <= (hsChg & ~((wrEn && addr == OFS_HS_CLR) ? wrData[1:0] : 2'b0))
             | ((wrEn && addr == OFS_HS_SET) ? wrData[1:0] : 2'b0)
             | {dsrIn ^ dsrQ, ctsIn ^ ctsQ};
    end
  end

  assign lsrView = {sticky, evt.holdEmpty, evt.shiftEmpty, 1'b0};
  assign divisor = DIV_W'({divHi, divLo});

  always_comb begin
    strobe.txLoad = ctrlReg[7] ? goodEv : (wrEn && addr == OFS_DATA);
    strobe.txByte = ctrlReg[7] ? evt.rxByte : wrData;
  end

  assign irq = (rxCmdReg[6:5] == 2'b01 && sticky[4])
            || (rxCmdReg[4] && |sticky[3:0])
            || (txCmdReg[6:5] == 2'b01 && txCmdReg[4] && evt.holdEmpty);

  always_comb begin
    unique case (addr)
      OFS_LSR_CLR, OFS_LSR_SET: rdData = lsrView;
      OFS_HS_CLR, OFS_HS_SET:   rdData = {dsrIn, ctsIn, 4'b0, hsChg};
      OFS_DIV_HI: rdData = divHi;
      OFS_DIV_LO: rdData = divLo;
      OFS_CTRL:   rdData = ctrlReg;
      OFS_RXCMD:  rdData = rxCmdReg;
      OFS_TXCMD:  rdData = txCmdReg;
      OFS_DATA:   rdData = rxBuf;
      default:    rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/serport_top.sv
module serport_top import serport_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [5:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       rxd,
  output logic       txd,
  input  logic       dsrIn,
  input  logic       ctsIn,
  output logic       dtrOut,
  output logic       rtsOut,
  output logic       irq
);
  ctlStrobe_t       strobe;
  dpEvent_t         evt;
  logic [7:0]       ctrlReg, rxCmdReg, txCmdReg, lsrView;
  logic [DIV_W-1:0] divisor;

  serport_ctl #(.DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn), .addr(busAddr),
    .wrData(busWrData), .rdData(busRdData), .dsrIn(dsrIn), .ctsIn(ctsIn),
    .evt(evt), .strobe(strobe), .ctrlReg(ctrlReg), .rxCmdReg(rxCmdReg),
    .txCmdReg(txCmdReg), .lsrView(lsrView), .divisor(divisor), .irq(irq));

  serport_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eight(ctrlReg[3]), .parEn(ctrlReg[2]),
    .parOdd(ctrlReg[1]), .twoStop(ctrlReg[0]), .loopMode(ctrlReg[6]),
    .rxEn(rxCmdReg[7]), .txEn(txCmdReg[7]), .txBreak(txCmdReg[1]),
    .divisor(divisor), .rxdPin(rxd), .txdPin(txd), .evt(evt));

  assign dtrOut = ctrlReg[5];
  assign rtsOut = ctrlReg[4];
endmodule

// File: rtl/serport_chk.sv
module serport_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txd,
  input logic       irq,
  input logic       wrEn,
  input logic       rdEn,
  input logic [5:0] addr,
  input logic [7:0] wrData,
  input logic [7:0] ctrlReg,
  input logic [7:0] rxCmdReg,
  input logic [7:0] txCmdReg,
  input logic [7:0] lsr,
  input logic       rxDone,
  input logic       rxBrk
);
  a_r10_loop_line_high: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[6] |-> txd);

  a_r12_break_holds_low: assert property (@(posedge clk) disable iff (!rstN)
    (txCmdReg[1] && !ctrlReg[6]) |-> !txd);

  a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !rxBrk && lsr[7]) |=> lsr[5]);

  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 6'h24 && !rxDone && !(wrEn && addr == 6'h04)) |=> !lsr[7]);

  a_r8_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lsr[6] && !(wrEn && addr == 6'h00 && wrData[6])) |=> lsr[6]);

  a_r13_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rxCmdReg[6:5] != 2'b01 && !rxCmdReg[4] && !(txCmdReg[6:5] == 2'b01 && txCmdReg[4])) |-> !irq);
endmodule

bind serport_top serport_chk u_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .irq(irq), .wrEn(busWrEn), .rdEn(busRdEn),
  .addr(busAddr), .wrData(busWrData), .ctrlReg(ctrlReg), .rxCmdReg(rxCmdReg),
  .txCmdReg(txCmdReg), .lsr(lsrView), .rxDone(evt.rxDone), .rxBrk(evt.rxBrk));

// File: tb/serport_top_tb.sv
module serport_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWrData = '0, busRdData;
  logic rxd = 1'b1, txd, dsrIn = 1'b0, ctsIn = 1'b0, dtrOut, rtsOut, irq;

  serport_top u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nErr = 0;
  int bitClks = 16;
  logic fEight = 1'b1, fPar = 1'b0, fOdd = 1'b0, fTwo = 1'b0;
  logic monEn = 1'b1;
  logic [7:0] txExp[$];
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    #1 v = busRdData;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic setFmt(input logic [7:0] c);
    wr(6'h18, c);
    fEight = c[3]; fPar = c[2]; fOdd = c[1]; fTwo = c[0];
  endtask

  function automatic logic parOf(input logic [7:0] d);
    return (^(fEight ? d : {1'b0, d[6:0]})) ^ fOdd;
  endfunction

  // Driver: send host byte, scoreboard records expected line byte
  task automatic txSend(input logic [7:0] d);
    txExp.push_back(fEight ? d : {1'b0, d[6:0]});
    wr(6'h24, d);
  endtask

  task automatic drainTx();
    while (txExp.size() != 0) @(negedge clk);
    repeat (bitClks * 2) @(negedge clk);
  endtask

  task automatic holdBit(input logic v);
    rxd = v;
    repeat (bitClks) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input logic badPar, input logic badStop);
    @(negedge clk);
    holdBit(1'b0);
    for (int i = 0; i < (fEight ? 8 : 7); i++) holdBit(d[i]);
    if (fPar) holdBit(parOf(d) ^ badPar);
    holdBit(~badStop);
    if (fTwo) holdBit(1'b1);
    holdBit(1'b1);
  endtask

  // Monitor: decode txd frames and compare with scoreboard
  initial begin
    logic [7:0] got;
    logic bitv;
    forever begin
      @(negedge clk);
      if (monEn && txd === 1'b0) begin
        got = '0;
        repeat (bitClks/2 - 1) @(negedge clk);
        chk("R2 start bit", txd, 1'b0);
        for (int i = 0; i < (fEight ? 8 : 7); i++) begin
          repeat (bitClks) @(negedge clk);
          got[i] = txd;
        end
        if (fPar) begin
          repeat (bitClks) @(negedge clk);
          bitv = txd;
          chk("R2 parity bit", bitv, parOf(got));
        end
        repeat (bitClks) @(negedge clk);
        chk("R2 stop bit", txd, 1'b1);
        if (fTwo) begin
          repeat (bitClks) @(negedge clk);
          chk("R2 second stop bit", txd, 1'b1);
        end
        if (txExp.size() == 0) chk("R2 unexpected frame", got, 8'hxx);
        else chk("R2 tx byte", got, txExp.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdChk("R1 line status", 6'h00, 8'h06);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 dtr/rts", {dtrOut, rtsOut}, 2'b00);
    rdChk("R14 handshake reset", 6'h08, 8'h00);

    wr(6'h10, 8'h00); wr(6'h14, 8'h00);
    setFmt(8'h08);
    wr(6'h1C, 8'h80); wr(6'h20, 8'h80);

    // R2 8N1
    txSend(8'h55); txSend(8'hC3); drainTx();
    rdChk("R9 idle after tx", 6'h00, 8'h06);
    // R2 8 data, odd parity, two stops
    setFmt(8'h0F); txSend(8'hA5); drainTx();
    setFmt(8'h0C); txSend(8'h07); drainTx();
    // R3 divisor 2 -> 48 clocks per bit
    setFmt(8'h08); wr(6'h14, 8'h02); bitClks = 48;
    rdChk("R3 divisor low", 6'h14, 8'h02);
    txSend(8'h3E); drainTx();
    wr(6'h14, 8'h00); bitClks = 16;

    // R9 transmitter disabled keeps holding byte full
    wr(6'h20, 8'h00);
    txSend(8'h12);
    repeat (40) @(negedge clk);
    rdChk("R9 holding full, shifter idle", 6'h00, 8'h02);
    chk("R2 disabled line idle", txd, 1'b1);
    wr(6'h20, 8'h80);
    repeat (20) @(negedge clk);
    rdChk("R9 shifter busy", 6'h00, 8'h04);
    drainTx();

    // R4 receive
    sendRx(8'h3C, 1'b0, 1'b0);
    rdChk("R4 data ready", 6'h00, 8'h86);
    rdChk("R4 data", 6'h24, 8'h3C);
    rdChk("R4 ready cleared", 6'h00, 8'h06);
    // R5 overrun
    sendRx(8'h11, 1'b0, 1'b0);
    sendRx(8'h22, 1'b0, 1'b0);
    rdChk("R5 overrun flag", 6'h00, 8'hA6);
    rdChk("R5 first byte kept", 6'h24, 8'h11);
    // R8 clear / set ports
    wr(6'h00, 8'h78);
    rdChk("R8 cleared", 6'h00, 8'h06);
    wr(6'h04, 8'h48);
    rdChk("R8 set port", 6'h00, 8'h4E);
    repeat (50) @(negedge clk);
    rdChk("R8 sticky", 6'h00, 8'h4E);
    wr(6'h00, 8'h40);
    rdChk("R8 partial clear", 6'h00, 8'h0E);
    wr(6'h00, 8'h08);
    // R6 framing and parity
    sendRx(8'h5A, 1'b0, 1'b1);
    rdChk("R6 framing flag", 6'h00, 8'hC6);
    rdChk("R6 framing byte", 6'h24, 8'h5A);
    wr(6'h00, 8'h78);
    setFmt(8'h0C);
    sendRx(8'h07, 1'b1, 1'b0);
    rdChk("R6 parity flag", 6'h00, 8'h96);
    rdChk("R6 parity byte", 6'h24, 8'h07);
    wr(6'h00, 8'h78);
    setFmt(8'h0E);
    sendRx(8'h07, 1'b0, 1'b0);
    rdChk("R6 odd parity good", 6'h00, 8'h86);
    rdChk("R6 odd parity byte", 6'h24, 8'h07);
    // R7 break
    setFmt(8'h08);
    @(negedge clk); rxd = 1'b0;
    repeat (12 * 16) @(negedge clk);
    rxd = 1'b1;
    repeat (32) @(negedge clk);
    rdChk("R7 break flag only", 6'h00, 8'h0E);
    wr(6'h00, 8'h08);
    // R2/R4 seven bits
    setFmt(8'h00);
    txSend(8'hFF); drainTx();
    sendRx(8'hD5, 1'b0, 1'b0);
    rdChk("R4 seven-bit byte", 6'h24, 8'h55);
    setFmt(8'h08);

    // R10 loopback
    monEn = 1'b0;
    setFmt(8'h48);
    wr(6'h24, 8'h5A);
    begin
      int lows = 0;
      for (int i = 0; i < 250; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk("R10 txd held high", lows, 0);
    end
    rdChk("R10 looped ready", 6'h00, 8'h86);
    rdChk("R10 looped byte", 6'h24, 8'h5A);
    setFmt(8'h08);
    monEn = 1'b1;

    // R11 auto echo
    setFmt(8'h88);
    wr(6'h24, 8'h01);
    rdChk("R11 host write ignored", 6'h00, 8'h06);
    txExp.push_back(8'h96);
    sendRx(8'h96, 1'b0, 1'b0);
    drainTx();
    rdChk("R11 echoed byte received", 6'h24, 8'h96);
    setFmt(8'h08);

    // R12 break generation
    monEn = 1'b0;
    wr(6'h20, 8'h82);
    repeat (5) @(negedge clk);
    chk("R12 line low", txd, 1'b0);
    repeat (100) @(negedge clk);
    chk("R12 line stays low", txd, 1'b0);
    wr(6'h20, 8'h80);
    repeat (3) @(negedge clk);
    chk("R12 line released", txd, 1'b1);
    monEn = 1'b1;

    // R13 interrupt
    wr(6'h1C, 8'hA0);
    chk("R13 no rx source", irq, 1'b0);
    sendRx(8'h44, 1'b0, 1'b0);
    chk("R13 rx ready irq", irq, 1'b1);
    rdChk("R13 rx byte", 6'h24, 8'h44);
    chk("R13 irq after read", irq, 1'b0);
    wr(6'h1C, 8'h90);
    wr(6'h04, 8'h20);
    chk("R13 error irq", irq, 1'b1);
    wr(6'h00, 8'h20);
    chk("R13 error cleared", irq, 1'b0);
    wr(6'h1C, 8'h80);
    wr(6'h20, 8'h90);
    chk("R13 tx mode not selected", irq, 1'b0);
    wr(6'h20, 8'hB0);
    chk("R13 tx empty irq", irq, 1'b1);
    wr(6'h20, 8'h80);
    chk("R13 tx irq off", irq, 1'b0);

    // R14 handshake and modem outputs
    setFmt(8'h38);
    chk("R14 dtr/rts on", {dtrOut, rtsOut}, 2'b11);
    setFmt(8'h28);
    chk("R14 dtr only", {dtrOut, rtsOut}, 2'b10);
    setFmt(8'h08);
    @(negedge clk); ctsIn = 1'b1;
    repeat (2) @(negedge clk);
    rdChk("R14 cts level+change", 6'h08, 8'h41);
    dsrIn = 1'b1;
    repeat (2) @(negedge clk);
    rdChk("R14 dsr level+change", 6'h08, 8'hC3);
    wr(6'h08, 8'hFF);
    rdChk("R14 changes cleared", 6'h08, 8'hC0);
    wr(6'h0C, 8'h02);
    rdChk("R14 set port", 6'h08, 8'hC2);
    wr(6'h08, 8'h02);
    rdChk("R14 clear port", 6'h08, 8'hC0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule